// File: doc/BRIEF.md
# Receive Port Nibble Multiplexer

This block carries receive samples out through a six-pin port that is narrower than a sample. It takes one 10-bit sample per handshake and sends it as two nibbles on two consecutive clock cycles: first the high nibble, then the low nibble. A sync flag marks which nibble is on the port. Each nibble is placed against the top pin. Any port bits it does not fill are driven to zero.

Three plain control bits set the behaviour. In practice a register file drives them:
- The split bit picks between an uneven division (six high bits and four low bits) and an even one (five and five).
- The bypass bit turns on a reduced-resolution mode. In this mode only the six most significant bits of each sample leave, in one cycle, and the sync flag stays low.
- The high-impedance bit removes the pad output enable.

Samples arrive over a valid/ready handshake. A sample transfers on a clock edge where `smp_valid` and `smp_ready` are both high. While `smp_valid` is high and `smp_ready` is low, the source must hold `smp_data` stable. In nibble modes, `smp_ready` drops for the one cycle in which the low nibble still owes the port. In bypass mode, `smp_ready` stays high, so a new sample can transfer on every cycle. The output side has no back-pressure: the pins take a nibble on every cycle in which `port_valid` is high.

Top module: `rx_nibble_mux`

## Requirements
- R1: During and straight after reset, `port_valid`, `port_sync` and `port_data` are 0 and `smp_ready` is 1.
- R2: In the uneven split (`cfg_bypass`=0, `cfg_even_split`=0), a sample S that transfers at edge k has these outputs:
  - After edge k: `port_data`=S[9:4] and `port_sync`=1.
  - After edge k+1: `port_data`={S[3:0],2'b00} and `port_sync`=0.
- R3: In the even split (`cfg_bypass`=0, `cfg_even_split`=1), the same two cycles carry {S[9:5],1'b0} with sync 1, then {S[4:0],1'b0} with sync 0.
- R4: In bypass (`cfg_bypass`=1), a sample S that transfers at edge k gives `port_data`=S[9:4] and `port_sync`=0 after edge k, for one cycle only.
- R5: `smp_ready` is 0 exactly in the cycle where a low nibble is still owed; otherwise it is 1. An offered sample is not taken in that cycle.
- R6: The split and bypass settings are captured with each sample. A change to those settings after the transfer does not alter that sample's low nibble.
- R7: `port_oe` is the inverse of `cfg_hiz` at all times, and it does not stop or alter the data stream.
- R8: In a cycle that carries no nibble, `port_valid`, `port_sync` and `port_data` are all 0.
- R9: When `cfg_bypass` and `cfg_even_split` are both 1, bypass wins and R4 applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock, one nibble per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | A sample is offered |
| smp_ready | output | 1 | Block can take a sample this cycle |
| smp_data | input | SAMPLE_W (10) | Receive sample |
| cfg_bypass | input | 1 | 1: one six-bit word per sample |
| cfg_even_split | input | 1 | 1: five/five split, 0: six/four split |
| cfg_hiz | input | 1 | 1: pad drivers disabled |
| port_valid | output | 1 | A nibble or word is on `port_data` |
| port_data | output | PORT_W (6) | Top-justified nibble or word |
| port_sync | output | 1 | 1 while the high nibble is out |
| port_oe | output | 1 | Pad output enable |

## Verification
The bench builds the block with its default widths: a 10-bit sample on a 6-bit port. At these widths every formatting variant is visible on the pins:
- the six-bit high nibble that fills the port;
- the four-bit low nibble with two zero bits below it;
- the two five-bit nibbles, each with one zero bit.

At these widths the random mix of valid gaps and setting changes also lands a setting change inside an open pair. This exercises the per-sample capture of the split.

// File: rtl/rxnm_pkg.sv
package rxnm_pkg;
  typedef enum logic [1:0] {
    SPLIT_WIDE   = 2'd0,
    SPLIT_EVEN   = 2'd1,
    SPLIT_BYPASS = 2'd2
  } split_e;
endpackage

// File: rtl/rxnm_mode_dec.sv
module rxnm_mode_dec
  import rxnm_pkg::*;
(
  input  logic   bypass,
  input  logic   even,
  output split_e mode
);
  // Bypass takes priority over the split selection.
  always_comb begin
    if (bypass)    mode = SPLIT_BYPASS;
    else if (even) mode = SPLIT_EVEN;
    else           mode = SPLIT_WIDE;
  end
endmodule

// File: rtl/rxnm_pair_seq.sv
module rxnm_pair_seq
  import rxnm_pkg::*;
#(
  parameter int SAMPLE_W = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_data,
  input  split_e              mode_in,
  output logic                in_ready,
  output logic                take,
  output logic                low_pend,
  output logic [SAMPLE_W-1:0] smp_q,
  output split_e              mode_q
);
  logic phase_q;

  assign in_ready = !phase_q;
  assign take     = in_valid && in_ready;
  assign low_pend = phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      smp_q   <= '0;
      mode_q  <= SPLIT_WIDE;
    end else if (take) begin
      smp_q   <= in_data;
      mode_q  <= mode_in;
      phase_q <= (mode_in != SPLIT_BYPASS);
    end else if (phase_q) begin
      phase_q <= 1'b0;
    end
  end
endmodule

// File: rtl/rxnm_format.sv
module rxnm_format
  import rxnm_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int PORT_W   = 6
) (
  input  logic [SAMPLE_W-1:0] smp,
  input  split_e              mode,
  input  logic                low_half,
  output logic [PORT_W-1:0]   word
);
  localparam int WIDE_LO = SAMPLE_W - PORT_W;
  localparam int EVEN_HI = (SAMPLE_W + 1) / 2;
  localparam int EVEN_LO = SAMPLE_W - EVEN_HI;

  logic [PORT_W-1:0] wide_hi, wide_lo, even_hi, even_lo;

  // Every field is pushed against the top port bit; the vacated low bits are zero.
  assign wide_hi = smp[SAMPLE_W-1 -: PORT_W];
  assign wide_lo = PORT_W'(smp[WIDE_LO-1:0]) << (PORT_W - WIDE_LO);
  assign even_hi = PORT_W'(smp[SAMPLE_W-1 -: EVEN_HI]) << (PORT_W - EVEN_HI);
  assign even_lo = PORT_W'(smp[EVEN_LO-1:0]) << (PORT_W - EVEN_LO);

  always_comb begin
    unique case (mode)
      SPLIT_EVEN:   word = low_half ? even_lo : even_hi;
      SPLIT_BYPASS: word = wide_hi;
      default:      word = low_half ? wide_lo : wide_hi;
    endcase
  end
endmodule

// File: rtl/rx_nibble_mux.sv
module rx_nibble_mux
  import rxnm_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int PORT_W   = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid,
  output logic                smp_ready,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic                cfg_bypass,
  input  logic                cfg_even_split,
  input  logic                cfg_hiz,
  output logic                port_valid,
  output logic [PORT_W-1:0]   port_data,
  output logic                port_sync,
  output logic                port_oe
);
  split_e              mode_now, mode_q, fmt_mode;
  logic                take, low_pend;
  logic [SAMPLE_W-1:0] smp_q, fmt_src;
  logic [PORT_W-1:0]   fmt_word;
  logic                emit;

  rxnm_mode_dec u_dec (
    .bypass (cfg_bypass),
    .even   (cfg_even_split),
    .mode   (mode_now)
  );

  rxnm_pair_seq #(.SAMPLE_W(SAMPLE_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (smp_valid),
    .in_data  (smp_data),
    .mode_in  (mode_now),
    .in_ready (smp_ready),
    .take     (take),
    .low_pend (low_pend),
    .smp_q    (smp_q),
    .mode_q   (mode_q)
  );

  // A fresh sample is formatted straight from the input; a pending low half from the held copy.
  assign fmt_src  = take ? smp_data : smp_q;
  assign fmt_mode = take ? mode_now : mode_q;
  assign emit     = take || low_pend;

  rxnm_format #(.SAMPLE_W(SAMPLE_W), .PORT_W(PORT_W)) u_fmt (
    .smp      (fmt_src),
    .mode     (fmt_mode),
    .low_half (low_pend),
    .word     (fmt_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_valid <= 1'b0;
      port_data  <= '0;
      port_sync  <= 1'b0;
    end else begin
      port_valid <= emit;
      port_data  <= emit ? fmt_word : '0;
      port_sync  <= take && (mode_now != SPLIT_BYPASS);
    end
  end

  assign port_oe = !cfg_hiz;
endmodule

// File: rtl/rx_nibble_mux_chk.sv
module rx_nibble_mux_chk
  import rxnm_pkg::*;
#(
  parameter int PORT_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              smp_valid,
  input logic              smp_ready,
  input logic              port_valid,
  input logic [PORT_W-1:0] port_data,
  input logic              port_sync,
  input split_e            mode_q
);
  // R2 / R3: a high nibble is always followed by its low nibble
  p_pair_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    port_sync |=> (port_valid && !port_sync));

  // R5: no new sample while a low nibble is owed
  p_no_mix_r5: assert property (@(posedge clk) disable iff (!rst_n)
    port_sync |-> !smp_ready);

  // R4: bypass never raises sync
  p_bypass_sync_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (port_valid && mode_q == SPLIT_BYPASS) |-> !port_sync);

  // R3: five-bit nibbles leave the bottom pin at zero
  p_even_pad_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (port_valid && mode_q == SPLIT_EVEN) |-> (port_data[0] == 1'b0));

  // R2: four-bit low nibble leaves two bottom pins at zero
  p_wide_pad_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (port_valid && !port_sync && mode_q == SPLIT_WIDE) |-> (port_data[1:0] == 2'b00));

  // R8: idle cycles are all zero
  p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !port_valid |-> (port_data == '0 && !port_sync));

  // R5: an accepted sample appears on the next cycle
  p_accept_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_ready) |=> port_valid);
endmodule

bind rx_nibble_mux rx_nibble_mux_chk #(.PORT_W(PORT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .smp_valid  (smp_valid),
  .smp_ready  (smp_ready),
  .port_valid (port_valid),
  .port_data  (port_data),
  .port_sync  (port_sync),
  .mode_q     (mode_q)
);

// File: tb/tb_rx_nibble_mux.sv
module tb_rx_nibble_mux;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       smp_valid = 1'b0;
  logic       smp_ready;
  logic [9:0] smp_data = '0;
  logic       cfg_bypass = 1'b0, cfg_even_split = 1'b0, cfg_hiz = 1'b0;
  logic       port_valid, port_sync, port_oe;
  logic [5:0] port_data;

  int checks = 0;
  int failures = 0;

  // bench model state
  logic       m_phase = 1'b0;
  logic [9:0] m_smp = '0;
  int         m_md = 0;
  logic       exp_v = 1'b0, exp_sync = 1'b0;
  logic [5:0] exp_d = '0;
  string      exp_tag = "R8";
  logic       last_stall = 1'b0;
  logic [9:0] last_d = '0;

  always #10 clk = ~clk;

  rx_nibble_mux dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_data(smp_data), .cfg_bypass(cfg_bypass), .cfg_even_split(cfg_even_split),
    .cfg_hiz(cfg_hiz), .port_valid(port_valid), .port_data(port_data),
    .port_sync(port_sync), .port_oe(port_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  function automatic logic [5:0] hi_word(input int md, input logic [9:0] s);
    if (md == 1) return {s[9:5], 1'b0};
    return s[9:4];
  endfunction

  function automatic logic [5:0] lo_word(input int md, input logic [9:0] s);
    if (md == 1) return {s[4:0], 1'b0};
    return {s[3:0], 2'b00};
  endfunction

  task automatic step(input logic v, input logic [9:0] d, input logic b,
                      input logic e, input logic z);
    bit acc;
    int md;
    @(negedge clk);
    chk(port_valid == exp_v, {exp_tag, " valid"}, int'(port_valid), int'(exp_v));
    chk(port_sync == exp_sync, {exp_tag, " sync"}, int'(port_sync), int'(exp_sync));
    chk(port_data == exp_d, {exp_tag, " data"}, int'(port_data), int'(exp_d));
    chk(smp_ready == !m_phase, "R5 ready", int'(smp_ready), int'(!m_phase));
    smp_valid = v; smp_data = d; cfg_bypass = b; cfg_even_split = e; cfg_hiz = z;
    #1;
    chk(port_oe == !z, "R7 oe", int'(port_oe), int'(!z));
    md  = b ? 2 : (e ? 1 : 0);
    acc = v && !m_phase;
    last_stall = v && m_phase;
    last_d = d;
    if (acc) begin
      m_smp = d; m_md = md;
      exp_v = 1'b1;
      exp_sync = (md != 2);
      exp_d = hi_word(md, d);
      m_phase = (md != 2);
      exp_tag = (b && e) ? "R9" : (md == 2 ? "R4" : (md == 1 ? "R3" : "R2"));
    end else if (m_phase) begin
      exp_v = 1'b1; exp_sync = 1'b0;
      exp_d = lo_word(m_md, m_smp);
      m_phase = 1'b0;
      exp_tag = (md != m_md) ? "R6" : (m_md == 1 ? "R3" : "R2");
    end else begin
      exp_v = 1'b0; exp_sync = 1'b0; exp_d = '0;
      exp_tag = "R8";
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd4711));
    repeat (2) @(negedge clk);
    // R1: reset state
    chk(port_valid == 1'b0 && port_sync == 1'b0, "R1 flags", int'({port_valid, port_sync}), 0);
    chk(port_data == 6'd0, "R1 data", int'(port_data), 0);
    chk(smp_ready == 1'b1, "R1 ready", int'(smp_ready), 1);
    rst_n = 1'b1;

    // directed: uneven split, even split, bypass, both bits (R9)
    step(1, 10'h3A5, 0, 0, 0);
    step(1, 10'h155, 0, 0, 0);   // offered while low nibble owed: not taken (R5)
    step(1, 10'h155, 0, 1, 0);
    step(0, 10'h000, 0, 1, 0);
    step(1, 10'h2CB, 1, 0, 0);
    step(1, 10'h3FF, 1, 1, 1);
    step(1, 10'h001, 1, 0, 1);
    // R6: even split captured, then control flips to uneven mid-pair
    step(1, 10'h21F, 0, 1, 0);
    step(0, 10'h000, 0, 0, 0);
    step(0, 10'h000, 1, 0, 0);
    step(0, 10'h000, 0, 0, 1);   // R8 idle with pads off (R7)
    step(0, 10'h000, 0, 0, 0);

    // constrained random: respects the hold-while-stalled rule
    for (int i = 0; i < 4000; i++) begin
      logic v;
      logic [9:0] d;
      logic b, e, z;
      if (last_stall) begin
        v = 1'b1; d = last_d;
      end else begin
        v = ($urandom % 4) != 0;
        d = 10'($urandom);
      end
      b = ($urandom % 5) == 0;
      e = $urandom % 2;
      z = ($urandom % 8) == 0;
      step(v, d, b, e, z);
    end
    step(0, 10'h000, 0, 0, 0);
    step(0, 10'h000, 0, 0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule